// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter with Coherent Byte Reads

This block keeps a 16-bit free-running up-counter that advances by one on each clock in which an external prescaler tick is high. An 8-bit processor bus sees the counter as two byte registers, one holding the upper byte and one holding the lower byte. The full 16-bit value is also driven out directly for compare logic elsewhere in the timer.

A byte-wide bus cannot read 16 bits at once, and the counter may step between the two reads. To keep the pair consistent, a read of the upper byte also copies the lower byte into a holding register. If the lower byte is read in the very next cycle, the held copy is returned. Software that reads upper-then-lower back to back therefore always gets the count as it stood when the upper byte was read. The counter itself never pauses, and writes to either byte do not change it.

Top module: `cohtimer_top`

## Requirements
- R1: While reset is held low at a clock edge, the counter clears to 0x0000 and the read data output clears to 0x00.
- R2: The counter adds one on every clock edge where `tick_en` is high, and holds its value on edges where `tick_en` is low.
- R3: When the counter is 0xFFFF and `tick_en` is high, it becomes 0x0000 on the next edge.
- R4: A read strobe at offset 0x0E places the counter's bits 15:8, as they were in the strobe cycle, on `bus_rdata` from the following cycle on.
- R5: A read at offset 0x0F in the cycle directly after a read at 0x0E returns the bits 7:0 that the counter held in the 0x0E read cycle. This holds even if the counter has stepped in between, including a carry into the upper byte.
- R6: A read at offset 0x0F that does not directly follow a read at 0x0E returns the counter's live bits 7:0 from its own strobe cycle.
- R7: Reads at any offset never stop or alter the counting; the counter keeps advancing during and between the two byte reads.
- R8: A write strobe with any data, at offset 0x0E, 0x0F or elsewhere, leaves the counter exactly as R2 and R3 would have it.
- R9: A read at any offset other than 0x0E and 0x0F returns 0x00. In a cycle with no read strobe, `bus_rdata` keeps its previous value.
- R10: `count_out` always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Prescaled tick; counter steps on edges where it is high |
| bus_addr | input | 6 | Register offset of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per byte read |
| bus_wr | input | 1 | Write strobe (ignored by the counter) |
| bus_wdata | input | 8 | Write data (ignored by the counter) |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the strobe |
| count_out | output | 16 | Live counter value for compare logic |

## Verification
A counter that skips or stalls a step shows on `count_out` at the very next edge. A mistake there also shows up later in every byte read. A holding register that captures at the wrong time, or a "directly after" flag that stays set too long, is only visible one cycle after the low-byte strobe. It is also hidden unless the counter moved between the two reads. For that reason the high-then-low pairs are issued while ticking, both at a low-byte carry and at full wrap, and a pair with a one-cycle gap checks that the flag clears.

// File: rtl/cohtimer_pkg.sv
// Shared types for the coherent-read timer counter.
// Assumes: one bus access of at most one kind per cycle.
package cohtimer_pkg;

    // Kind of read access decoded from the bus in the current cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_HI    = 2'd1,
        ACC_LO    = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

endpackage

// File: rtl/cohtimer_count.sv
// Free-running up-counter that steps once per prescaled tick.
// Assumes: tick_en is synchronous to clk; wraps at all-ones.
module cohtimer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Advance the count on each tick, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q == CNT_MAX) |=> cnt_q == '0);

endmodule

// File: rtl/cohtimer_decode.sv
// Decodes a bus read strobe and offset into an access kind.
// Assumes: strobes are one-cycle pulses; purely combinational.
module cohtimer_decode
    import cohtimer_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter logic [ADDR_W-1:0] HI_OFS = 6'h0E,
    parameter logic [ADDR_W-1:0] LO_OFS = 6'h0F
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_e              acc
);
    // Classify the current bus cycle
    always_comb begin
        if (!bus_rd)
            acc = ACC_NONE;
        else if (bus_addr == HI_OFS)
            acc = ACC_HI;
        else if (bus_addr == LO_OFS)
            acc = ACC_LO;
        else
            acc = ACC_OTHER;
    end

endmodule

// File: rtl/cohtimer_rdport.sv
// Byte read port: returns the upper or lower counter byte. A high-byte read
// snapshots the lower byte; a low-byte read in the next cycle uses it.
// Assumes: CNT_W == 2*DATA_W; read data is registered (one-cycle latency).
module cohtimer_rdport
    import cohtimer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] cnt_hi;
    logic [DATA_W-1:0] cnt_lo;
    logic [DATA_W-1:0] lo_buf_q;
    logic              hi_prev_q;
    logic [DATA_W-1:0] rdata_d;

    assign cnt_hi = cnt[CNT_W-1 -: DATA_W];
    assign cnt_lo = cnt[DATA_W-1:0];

    // Snapshot the low byte on a high read and remember that it happened
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf_q  <= '0;
            hi_prev_q <= 1'b0;
        end else begin
            hi_prev_q <= (acc == ACC_HI);
            if (acc == ACC_HI)
                lo_buf_q <= cnt_lo;
        end
    end

    // Pick the byte to return for this access
    always_comb begin
        unique case (acc)
            ACC_HI:  rdata_d = cnt_hi;
            ACC_LO:  rdata_d = hi_prev_q ? lo_buf_q : cnt_lo;
            default: rdata_d = '0;
        endcase
    end

    // Register read data on a strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (acc != ACC_NONE)
            rdata_q <= rdata_d;
    end

    // R4
    hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_HI) |=> rdata_q == $past(cnt[CNT_W-1 -: DATA_W]));

    // R5
    lo_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_LO && $past(acc) == ACC_HI) |=> rdata_q == $past(cnt[DATA_W-1:0], 2));

    // R6
    lo_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_LO && $past(acc) != ACC_HI) |=> rdata_q == $past(cnt[DATA_W-1:0]));

    // R9
    other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_OTHER) |=> rdata_q == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE) |=> $stable(rdata_q));

endmodule

// File: rtl/cohtimer_top.sv
// Prescaled 16-bit timer counter with a byte-wide, coherent read port.
// Assumes: one bus access per cycle; writes target a read-only register pair.
module cohtimer_top
    import cohtimer_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] HI_OFS = 6'h0E,
    parameter logic [ADDR_W-1:0] LO_OFS = 6'h0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [2*DATA_W-1:0] count_out
);
    localparam int CNT_W = 2 * DATA_W;

    acc_e             acc;
    logic [CNT_W-1:0] cnt;

    cohtimer_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_q   (cnt)
    );

    cohtimer_decode #(.ADDR_W(ADDR_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)) u_decode (
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    cohtimer_rdport #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .cnt     (cnt),
        .rdata_q (bus_rdata)
    );

    assign count_out = cnt;

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !tick_en) |=> $stable(count_out));

    // R8
    wr_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !tick_en && bus_wdata != count_out[DATA_W-1:0])
        |=> count_out[DATA_W-1:0] != $past(bus_wdata));

endmodule

// File: tb/test_cohtimer_top.sv
module test_cohtimer_top;
    localparam logic [5:0] HI = 6'h0E;
    localparam logic [5:0] LO = 6'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [15:0] count_out;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        string      ctag;
    } item_t;
    item_t sb_q[$];

    logic [15:0] m_cnt = '0;
    logic [7:0]  m_buf = '0;
    logic        m_hi_prev = 1'b0;
    logic [7:0]  m_last = '0;

    always #2 clk = ~clk;

    cohtimer_top i_cohtimer_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_out(count_out)
    );

    // Reference count
    always @(posedge clk) begin
        if (!rst_n) m_cnt <= '0;
        else if (tick_en) m_cnt <= m_cnt + 16'd1;
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s bus_rdata=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s count_out=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle, pushes the expected read data for the next edge
    task automatic cyc(input logic rd, input logic wr, input logic [5:0] addr,
                       input logic [7:0] wd, input logic tk,
                       input string tag, input string ctag);
        item_t it;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd; tick_en = tk;
        if (rd) begin
            if (addr == HI) begin
                m_last = m_cnt[15:8];
                m_buf  = m_cnt[7:0];
            end else if (addr == LO) begin
                m_last = m_hi_prev ? m_buf : m_cnt[7:0];
            end else begin
                m_last = 8'h00;
            end
        end
        m_hi_prev = rd && (addr == HI);
        it.exp = m_last; it.tag = tag; it.ctag = ctag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check8(it.tag, bus_rdata, it.exp);
                check16(it.ctag, count_out, m_cnt);
            end
        end
    end

    task automatic finish_sim;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check8("R1", bus_rdata, 8'h00);
        check16("R1", count_out, 16'h0000);
        rst_n = 1'b1;

        // R2: counting and holding
        for (int i = 0; i < 6; i++) cyc(0, 0, 6'h00, 8'h00, 1, "R9 idle", "R2 tick");
        for (int i = 0; i < 4; i++) cyc(0, 0, 6'h00, 8'h00, 0, "R9 idle", "R2 hold");
        for (int i = 0; i < 8; i++) cyc(0, 0, 6'h00, 8'h00, i[0], "R9 idle", "R2 R10 alt");

        // R4 R5 R7: back-to-back pair while ticking
        cyc(1, 0, HI, 8'h00, 1, "R4 hi", "R7 count");
        cyc(1, 0, LO, 8'h00, 1, "R5 lo buffered", "R7 count");
        // Pairs with other tick patterns
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, HI, 8'h00, i[0], "R4 hi", "R7 count");
            cyc(1, 0, LO, 8'h00, i[1], "R5 lo buffered", "R7 count");
        end

        // R6: gap between reads, and a lone low read
        cyc(1, 0, HI, 8'h00, 1, "R4 hi", "R7 count");
        cyc(0, 0, 6'h00, 8'h00, 1, "R9 hold", "R7 count");
        cyc(1, 0, LO, 8'h00, 1, "R6 lo live", "R7 count");
        cyc(1, 0, LO, 8'h00, 1, "R6 lo live again", "R7 count");

        // R9: other offsets and hold
        cyc(1, 0, 6'h05, 8'h00, 1, "R9 other", "R2 tick");
        cyc(1, 0, 6'h0D, 8'h00, 0, "R9 other", "R2 hold");
        cyc(0, 0, 6'h00, 8'h00, 0, "R9 hold", "R2 hold");

        // R8: writes ignored
        cyc(0, 1, HI, 8'hA5, 0, "R9 hold", "R8 wr hi");
        cyc(0, 1, LO, 8'h5A, 0, "R9 hold", "R8 wr lo");
        cyc(0, 1, HI, 8'hFF, 1, "R9 hold", "R8 wr tick");
        cyc(0, 1, LO, 8'h00, 1, "R9 hold", "R8 wr tick");
        cyc(1, 0, LO, 8'h00, 0, "R8 lo after wr", "R8 count");

        // R5: low byte carry between the two reads
        while (m_cnt[7:0] != 8'hFF) cyc(0, 0, 6'h00, 8'h00, 1, "R9 idle", "R2 run");
        cyc(1, 0, HI, 8'h00, 1, "R4 hi at carry", "R7 count");
        cyc(1, 0, LO, 8'h00, 1, "R5 lo carry", "R7 count");

        // R3: run to full scale and wrap
        while (m_cnt != 16'hFFFF) cyc(0, 0, 6'h00, 8'h00, 1, "R9 idle", "R2 run");
        cyc(1, 0, HI, 8'h00, 1, "R4 hi at full", "R3 wrap");
        cyc(1, 0, LO, 8'h00, 1, "R5 lo at wrap", "R3 after wrap");
        cyc(1, 0, HI, 8'h00, 0, "R4 hi after wrap", "R3 hold");
        cyc(1, 0, LO, 8'h00, 0, "R5 lo after wrap", "R3 hold");

        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_sim();
    end
endmodule